// File: doc/BRIEF.md
# Machine-check error bank controller

This block keeps a row of machine-check reporting banks plus three global registers: capability, control and status. Each bank has four 64-bit registers: control, status, address and misc. Software reaches every register through a simple index-based register port. Reads return data combinationally for the index on the port. Writes commit on the clock edge where the write strobe is high.

A separate injection port posts an error record, made of a status word, a global status word, an address and a misc word, into a chosen bank. In the same cycle the block decides what to do with the record. It can ignore it, drop it because reporting is gated off, store it, mark an overflow on the record already held, or escalate. An accepted uncorrected error raises a one-cycle machine-check interrupt pulse. An uncorrected error that arrives while a machine check is already in progress, or while the operating system has not enabled machine checks, raises a one-cycle reset-request pulse instead.

Both ports carry no back-pressure. A request is taken in every cycle its strobe is high, and there is no ready signal. If an injection and a register write arrive in the same cycle, the injection is processed and the write is discarded.

Top module: `mchk_bank_ctrl`

## Requirements
- R1: After reset the global control register and every bank control register read all ones. Every bank status, address and misc register and the global status register read zero. The capability register reads the bank count in bits 7:0 and, in bit 8, a 1 when the global control register is implemented.
- R2: Register indices are 0x100 for capability, 0x101 for global control and 0x102 for global status. Bank n uses index 0x400+4n for control, +1 for status, +2 for address and +3 for misc. Any other index reads zero, and a write to it changes nothing.
- R3: Status bit 63 means valid, bit 62 means overflow and bit 61 means uncorrected. Global status bit 2 means a machine check is in progress. An injection whose bank number is not below the bank count, or whose status has bit 63 clear, changes no register and raises no pulse.
- R4: An uncorrected injection is dropped, with no register change and no pulse, when global control is implemented and is not all ones. It is also dropped when the target bank's control register is not all ones.
- R5: An uncorrected injection that passes the R4 gating while global status bit 2 is set, or while os_mce_en is low, pulses reset_req one cycle later and changes no register.
- R6: An accepted uncorrected injection stores the injected status, with bit 62 forced to 1 if the bank already held a valid record. It also stores the address, the misc word and the injected global status, and pulses mce_irq one cycle later.
- R7: A valid corrected injection (bit 61 clear) replaces status, address and misc when the held status is not valid or not uncorrected. In that case it forces bit 62 if the held record was valid. Otherwise it only sets bit 62 of the held status. It raises no pulse.
- R8: A write to a bank control register or to global control takes effect only if the value is all zeros or all ones. Bank status, address and misc and global status accept any value. The capability register ignores writes.
- R9: When the global control register is not implemented, it reads zero and does not gate uncorrected injections.
- R10: mce_irq and reset_req are single-cycle pulses and never both high. When an injection and a register write occur in the same cycle, the write is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| os_mce_en | input | 1 | Operating system has enabled machine-check delivery |
| reg_valid | input | 1 | Register request strobe |
| reg_write | input | 1 | 1 = write, 0 = read |
| reg_index | input | IDX_W | Register index |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Read data for reg_index (combinational) |
| inj_valid | input | 1 | Injection strobe |
| inj_bank | input | BANK_W | Target bank number |
| inj_status | input | 64 | Injected bank status word |
| inj_gstatus | input | 64 | Injected global status word |
| inj_addr | input | 64 | Injected address word |
| inj_misc | input | 64 | Injected misc word |
| mce_irq | output | 1 | Machine-check interrupt pulse |
| reset_req | output | 1 | System reset request pulse |

## Verification
The main instance is built with four banks and the global control register implemented. With four banks the last bank, the first unmapped index past it at 0x410, and out-of-range bank numbers from 4 up to 255 are all cheap to reach, and the bank-control and global-control gating of R4 can both be exercised. A second instance with two banks and no global control register covers the capability encoding without bit 8 and the zero read-back of R9. The reference model tracks every bank register and is compared against the read port and both pulses in every cycle.

// File: rtl/mchk_pkg.sv
package mchk_pkg;
  localparam int DW      = 64;
  localparam int ST_VAL  = 63;
  localparam int ST_OVR  = 62;
  localparam int ST_UC   = 61;
  localparam int GS_MCIP = 2;

  typedef enum logic [2:0] {
    ACT_NONE, ACT_DROP, ACT_RESET, ACT_UC, ACT_CE, ACT_OVF
  } inj_act_e;

  typedef enum logic [2:0] {
    RSEL_NONE, RSEL_GCAP, RSEL_GCTL, RSEL_GSTS, RSEL_BANK
  } rsel_e;

  // field order inside a bank is fixed: control, status, address, misc
  typedef enum logic [1:0] {
    FLD_CTL = 2'd0, FLD_STS = 2'd1, FLD_ADDR = 2'd2, FLD_MISC = 2'd3
  } fld_e;
endpackage

// File: rtl/mchk_reg_decode.sv
module mchk_reg_decode
  import mchk_pkg::*;
#(
  parameter int IDX_W = 12,
  parameter int NUM_BANKS = 10,
  parameter int BSEL_W = 4,
  parameter logic [IDX_W-1:0] BANK_BASE = 12'h400,
  parameter logic [IDX_W-1:0] GCAP_IDX = 12'h100,
  parameter logic [IDX_W-1:0] GCTL_IDX = 12'h101,
  parameter logic [IDX_W-1:0] GSTS_IDX = 12'h102
) (
  input  logic [IDX_W-1:0]  idx,
  output rsel_e             sel,
  output logic [BSEL_W-1:0] bank,
  output fld_e              fld
);
  localparam logic [IDX_W-1:0] SPAN = IDX_W'(4 * NUM_BANKS);

  logic [IDX_W-1:0] off;
  logic [IDX_W-1:0] quad;

  assign off  = idx - BANK_BASE;
  assign quad = off >> 2;
  assign bank = quad[BSEL_W-1:0];
  assign fld  = fld_e'(off[1:0]);

  always_comb begin
    if (idx == GCAP_IDX)                    sel = RSEL_GCAP;
    else if (idx == GCTL_IDX)               sel = RSEL_GCTL;
    else if (idx == GSTS_IDX)               sel = RSEL_GSTS;
    else if (idx >= BANK_BASE && off < SPAN) sel = RSEL_BANK;
    else                                    sel = RSEL_NONE;
  end
endmodule

// File: rtl/mchk_inject_eval.sv
module mchk_inject_eval
  import mchk_pkg::*;
#(
  parameter int BANK_W = 8,
  parameter int NUM_BANKS = 10,
  parameter bit GCTL_PRESENT = 1'b1
) (
  input  logic              inj_valid,
  input  logic [BANK_W-1:0] inj_bank,
  input  logic [DW-1:0]     inj_status,
  input  logic [DW-1:0]     bank_ctl,
  input  logic [DW-1:0]     bank_sts,
  input  logic [DW-1:0]     gctl,
  input  logic              mcip,
  input  logic              os_en,
  output inj_act_e          act,
  output logic [DW-1:0]     new_sts
);
  localparam logic [BANK_W:0] LIMIT = (BANK_W+1)'(NUM_BANKS);

  logic in_range;
  logic gate_off;
  logic held_val;
  logic held_uc;

  assign in_range = {1'b0, inj_bank} < LIMIT;
  assign gate_off = (GCTL_PRESENT && (gctl != '1)) || (bank_ctl != '1);
  assign held_val = bank_sts[ST_VAL];
  assign held_uc  = bank_sts[ST_UC];

  always_comb begin
    act     = ACT_NONE;
    new_sts = inj_status;
    if (inj_valid && in_range && inj_status[ST_VAL]) begin
      if (inj_status[ST_UC]) begin
        if (gate_off) begin
          act = ACT_DROP;
        end else if (mcip || !os_en) begin
          act = ACT_RESET;
        end else begin
          act = ACT_UC;
          if (held_val) new_sts[ST_OVR] = 1'b1;
        end
      end else if (!held_val || !held_uc) begin
        act = ACT_CE;
        if (held_val) new_sts[ST_OVR] = 1'b1;
      end else begin
        act     = ACT_OVF;
        new_sts = bank_sts;
        new_sts[ST_OVR] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/mchk_bank.sv
module mchk_bank
  import mchk_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  fld_e          wr_fld,
  input  logic [DW-1:0] wr_data,
  input  logic          rec_en,
  input  logic          ovf_en,
  input  logic [DW-1:0] rec_sts,
  input  logic [DW-1:0] rec_addr,
  input  logic [DW-1:0] rec_misc,
  output logic [DW-1:0] ctl_q,
  output logic [DW-1:0] sts_q,
  output logic [DW-1:0] addr_q,
  output logic [DW-1:0] misc_q
);
  logic ctl_legal;
  assign ctl_legal = (wr_data == '0) || (wr_data == '1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q  <= '1;
      sts_q  <= '0;
      addr_q <= '0;
      misc_q <= '0;
    end else if (rec_en) begin
      sts_q  <= rec_sts;
      addr_q <= rec_addr;
      misc_q <= rec_misc;
    end else if (ovf_en) begin
      sts_q[ST_OVR] <= 1'b1;
    end else if (wr_en) begin
      case (wr_fld)
        FLD_CTL:  if (ctl_legal) ctl_q <= wr_data;
        FLD_STS:  sts_q  <= wr_data;
        FLD_ADDR: addr_q <= wr_data;
        default:  misc_q <= wr_data;
      endcase
    end
  end
endmodule

// File: rtl/mchk_bank_ctrl.sv
module mchk_bank_ctrl
  import mchk_pkg::*;
#(
  parameter int NUM_BANKS = 10,
  parameter int IDX_W = 12,
  parameter int BANK_W = 8,
  parameter bit GCTL_PRESENT = 1'b1,
  parameter logic [IDX_W-1:0] BANK_BASE = 12'h400,
  parameter logic [IDX_W-1:0] GCAP_IDX = 12'h100,
  parameter logic [IDX_W-1:0] GCTL_IDX = 12'h101,
  parameter logic [IDX_W-1:0] GSTS_IDX = 12'h102
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              os_mce_en,
  input  logic              reg_valid,
  input  logic              reg_write,
  input  logic [IDX_W-1:0]  reg_index,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  input  logic              inj_valid,
  input  logic [BANK_W-1:0] inj_bank,
  input  logic [DW-1:0]     inj_status,
  input  logic [DW-1:0]     inj_gstatus,
  input  logic [DW-1:0]     inj_addr,
  input  logic [DW-1:0]     inj_misc,
  output logic              mce_irq,
  output logic              reset_req
);
  localparam int BSEL_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;
  localparam logic [DW-1:0] CAP_VAL =
    {55'd0, GCTL_PRESENT, 8'(NUM_BANKS)};

  rsel_e             dec_sel;
  logic [BSEL_W-1:0] dec_bank;
  fld_e              dec_fld;

  logic [DW-1:0] ctl_a  [NUM_BANKS];
  logic [DW-1:0] sts_a  [NUM_BANKS];
  logic [DW-1:0] addr_a [NUM_BANKS];
  logic [DW-1:0] misc_a [NUM_BANKS];
  logic [NUM_BANKS*DW-1:0] ctl_flat;

  logic [DW-1:0] gctl_q, gsts_q;
  logic          irq_q, rstreq_q;

  logic [DW-1:0] tgt_ctl, tgt_sts, new_sts;
  inj_act_e      act;
  logic          wr_go;
  logic          rec_any;

  assign wr_go   = reg_valid && reg_write && !inj_valid;
  assign rec_any = (act == ACT_UC) || (act == ACT_CE);

  mchk_reg_decode #(
    .IDX_W(IDX_W), .NUM_BANKS(NUM_BANKS), .BSEL_W(BSEL_W),
    .BANK_BASE(BANK_BASE), .GCAP_IDX(GCAP_IDX),
    .GCTL_IDX(GCTL_IDX), .GSTS_IDX(GSTS_IDX)
  ) u_dec (
    .idx(reg_index), .sel(dec_sel), .bank(dec_bank), .fld(dec_fld)
  );

  // pick the injection target without indexing past the array end
  always_comb begin
    tgt_ctl = '0;
    tgt_sts = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (inj_bank == BANK_W'(b)) begin
        tgt_ctl = ctl_a[b];
        tgt_sts = sts_a[b];
      end
    end
  end

  mchk_inject_eval #(
    .BANK_W(BANK_W), .NUM_BANKS(NUM_BANKS), .GCTL_PRESENT(GCTL_PRESENT)
  ) u_eval (
    .inj_valid(inj_valid), .inj_bank(inj_bank), .inj_status(inj_status),
    .bank_ctl(tgt_ctl), .bank_sts(tgt_sts), .gctl(gctl_q),
    .mcip(gsts_q[GS_MCIP]), .os_en(os_mce_en),
    .act(act), .new_sts(new_sts)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic hit_inj;
    assign hit_inj = (inj_bank == BANK_W'(b));

    mchk_bank u_bank (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_go && (dec_sel == RSEL_BANK) && (dec_bank == BSEL_W'(b))),
      .wr_fld(dec_fld), .wr_data(reg_wdata),
      .rec_en(rec_any && hit_inj),
      .ovf_en((act == ACT_OVF) && hit_inj),
      .rec_sts(new_sts), .rec_addr(inj_addr), .rec_misc(inj_misc),
      .ctl_q(ctl_a[b]), .sts_q(sts_a[b]),
      .addr_q(addr_a[b]), .misc_q(misc_a[b])
    );

    assign ctl_flat[b*DW +: DW] = ctl_a[b];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gctl_q   <= '1;
      gsts_q   <= '0;
      irq_q    <= 1'b0;
      rstreq_q <= 1'b0;
    end else begin
      irq_q    <= (act == ACT_UC);
      rstreq_q <= (act == ACT_RESET);
      if (act == ACT_UC)
        gsts_q <= inj_gstatus;
      else if (wr_go && dec_sel == RSEL_GSTS)
        gsts_q <= reg_wdata;
      if (GCTL_PRESENT && wr_go && dec_sel == RSEL_GCTL &&
          (reg_wdata == '0 || reg_wdata == '1))
        gctl_q <= reg_wdata;
    end
  end

  always_comb begin
    logic [DW-1:0] bc, bs, ba, bm;
    bc = '0; bs = '0; ba = '0; bm = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (dec_bank == BSEL_W'(b)) begin
        bc = ctl_a[b]; bs = sts_a[b]; ba = addr_a[b]; bm = misc_a[b];
      end
    end
    case (dec_sel)
      RSEL_GCAP: reg_rdata = CAP_VAL;
      RSEL_GCTL: reg_rdata = GCTL_PRESENT ? gctl_q : '0;
      RSEL_GSTS: reg_rdata = gsts_q;
      RSEL_BANK: begin
        case (dec_fld)
          FLD_CTL:  reg_rdata = bc;
          FLD_STS:  reg_rdata = bs;
          FLD_ADDR: reg_rdata = ba;
          default:  reg_rdata = bm;
        endcase
      end
      default:   reg_rdata = '0;
    endcase
  end

  assign mce_irq   = irq_q;
  assign reset_req = rstreq_q;
endmodule

// File: rtl/mchk_bank_ctrl_chk.sv
module mchk_bank_ctrl_chk #(
  parameter int NUM_BANKS = 10
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 inj_valid,
  input logic [63:0]          inj_status,
  input logic                 mce_irq,
  input logic                 reset_req,
  input logic [63:0]          gctl_q,
  input logic [NUM_BANKS*64-1:0] ctl_flat
);
  assert_one_outcome_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(mce_irq && reset_req));

  assert_irq_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mce_irq |-> $past(inj_valid && inj_status[63] && inj_status[61]));

  assert_reset_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |-> $past(inj_valid && inj_status[63] && inj_status[61]));

  assert_ignore_invalid_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (inj_valid && !inj_status[63]) |=> (!mce_irq && !reset_req));

  assert_ce_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (inj_valid && !inj_status[61]) |=> (!mce_irq && !reset_req));

  assert_gctl_legal_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (gctl_q == '0) || (gctl_q == '1));

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_ctl
    assert_bctl_legal_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_flat[b*64 +: 64] == '0) || (ctl_flat[b*64 +: 64] == '1));
  end
endmodule

bind mchk_bank_ctrl mchk_bank_ctrl_chk #(.NUM_BANKS(NUM_BANKS)) u_chk (
  .clk(clk), .rst_n(rst_n), .inj_valid(inj_valid), .inj_status(inj_status),
  .mce_irq(mce_irq), .reset_req(reset_req), .gctl_q(gctl_q),
  .ctl_flat(ctl_flat)
);

// File: tb/mchk_bank_ctrl_tb.sv
`timescale 1ns/100ps
module mchk_bank_ctrl_tb;
  localparam int NB = 4;
  localparam logic [63:0] V = 64'h8000_0000_0000_0000;
  localparam logic [63:0] O = 64'h4000_0000_0000_0000;
  localparam logic [63:0] U = 64'h2000_0000_0000_0000;
  localparam logic [63:0] ONES = '1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        os_mce_en, reg_valid, reg_write, inj_valid;
  logic [11:0] reg_index;
  logic [63:0] reg_wdata, reg_rdata, inj_status, inj_gstatus, inj_addr, inj_misc;
  logic [7:0]  inj_bank;
  logic        mce_irq, reset_req;

  logic        n_valid, n_write, n_inj;
  logic [11:0] n_index;
  logic [63:0] n_wdata, n_rdata, n_status;
  logic        n_irq, n_rst;

  mchk_bank_ctrl #(.NUM_BANKS(NB)) u_dut (
    .clk(clk), .rst_n(rst_n), .os_mce_en(os_mce_en),
    .reg_valid(reg_valid), .reg_write(reg_write), .reg_index(reg_index),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .inj_valid(inj_valid), .inj_bank(inj_bank), .inj_status(inj_status),
    .inj_gstatus(inj_gstatus), .inj_addr(inj_addr), .inj_misc(inj_misc),
    .mce_irq(mce_irq), .reset_req(reset_req)
  );

  mchk_bank_ctrl #(.NUM_BANKS(2), .GCTL_PRESENT(1'b0)) u_dut_ngc (
    .clk(clk), .rst_n(rst_n), .os_mce_en(1'b1),
    .reg_valid(n_valid), .reg_write(n_write), .reg_index(n_index),
    .reg_wdata(n_wdata), .reg_rdata(n_rdata),
    .inj_valid(n_inj), .inj_bank(8'd0), .inj_status(n_status),
    .inj_gstatus(64'h1), .inj_addr(64'hA5), .inj_misc(64'h5A),
    .mce_irq(n_irq), .reset_req(n_rst)
  );

  int tests = 0, fails = 0;
  string cur_req = "R1";

  // reference model state
  logic [63:0] m_ctl [NB], m_sts [NB], m_addr [NB], m_misc [NB];
  logic [63:0] m_gctl, m_gsts;
  logic        e_irq, e_rst;

  task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [63:0] mread(logic [11:0] i);
    int off;
    if (i == 12'h100) return {55'd0, 1'b1, 8'(NB)};
    if (i == 12'h101) return m_gctl;
    if (i == 12'h102) return m_gsts;
    off = int'(i) - 'h400;
    if (off >= 0 && off < 4*NB) begin
      case (off % 4)
        0: return m_ctl[off/4];
        1: return m_sts[off/4];
        2: return m_addr[off/4];
        default: return m_misc[off/4];
      endcase
    end
    return '0;
  endfunction

  task automatic mwrite(logic [11:0] i, logic [63:0] d);
    int off;
    off = int'(i) - 'h400;
    if (i == 12'h101) begin
      if (d == '0 || d == ONES) m_gctl = d;
    end else if (i == 12'h102) begin
      m_gsts = d;
    end else if (off >= 0 && off < 4*NB) begin
      case (off % 4)
        0: if (d == '0 || d == ONES) m_ctl[off/4] = d;
        1: m_sts[off/4] = d;
        2: m_addr[off/4] = d;
        default: m_misc[off/4] = d;
      endcase
    end
  endtask

  task automatic model_step();
    int b;
    logic [63:0] s;
    e_irq = 1'b0;
    e_rst = 1'b0;
    if (inj_valid) begin
      b = int'(inj_bank);
      if (b < NB && inj_status[63]) begin
        s = inj_status;
        if (inj_status[61]) begin
          if (m_gctl != ONES || m_ctl[b] != ONES) begin
            // dropped
          end else if (m_gsts[2] || !os_mce_en) begin
            e_rst = 1'b1;
          end else begin
            if (m_sts[b][63]) s[62] = 1'b1;
            m_sts[b] = s; m_addr[b] = inj_addr; m_misc[b] = inj_misc;
            m_gsts = inj_gstatus;
            e_irq = 1'b1;
          end
        end else if (!m_sts[b][63] || !m_sts[b][61]) begin
          if (m_sts[b][63]) s[62] = 1'b1;
          m_sts[b] = s; m_addr[b] = inj_addr; m_misc[b] = inj_misc;
        end else begin
          m_sts[b][62] = 1'b1;
        end
      end
    end else if (reg_valid && reg_write) begin
      mwrite(reg_index, reg_wdata);
    end
  endtask

  // one clock: compare read port, advance model, compare pulses
  task automatic cyc();
    #1;
    chk(cur_req, "rdata", reg_rdata, mread(reg_index));
    model_step();
    @(negedge clk);
    chk(cur_req, "mce_irq", {63'd0, mce_irq}, {63'd0, e_irq});
    chk(cur_req, "reset_req", {63'd0, reset_req}, {63'd0, e_rst});
  endtask

  task automatic idle_in();
    reg_valid = 0; reg_write = 0; inj_valid = 0;
  endtask

  task automatic peek(logic [11:0] i);
    idle_in(); reg_index = i; cyc();
  endtask

  task automatic poke(logic [11:0] i, logic [63:0] d);
    idle_in(); reg_valid = 1; reg_write = 1; reg_index = i; reg_wdata = d;
    cyc(); idle_in();
  endtask

  task automatic inj(logic [7:0] b, logic [63:0] s, logic [63:0] g,
                     logic [63:0] a, logic [63:0] m);
    inj_valid = 1; inj_bank = b; inj_status = s; inj_gstatus = g;
    inj_addr = a; inj_misc = m;
    cyc(); inj_valid = 0;
  endtask

  task automatic peek_bank(int b);
    for (int f = 0; f < 4; f++) peek(12'(12'h400 + 4*b + f));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    os_mce_en = 1; idle_in(); reg_index = 0; reg_wdata = 0;
    inj_bank = 0; inj_status = 0; inj_gstatus = 0; inj_addr = 0; inj_misc = 0;
    n_valid = 0; n_write = 0; n_inj = 0; n_index = 0; n_wdata = 0; n_status = 0;
    for (int b = 0; b < NB; b++) begin
      m_ctl[b] = ONES; m_sts[b] = 0; m_addr[b] = 0; m_misc[b] = 0;
    end
    m_gctl = ONES; m_gsts = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    cur_req = "R1";
    peek(12'h100); peek(12'h101); peek(12'h102);
    for (int b = 0; b < NB; b++) peek_bank(b);

    cur_req = "R2";
    for (int b = 0; b < NB; b++) begin
      poke(12'(12'h401 + 4*b), 64'h1111 * (b+1));
      poke(12'(12'h402 + 4*b), 64'hA000 + b);
      poke(12'(12'h403 + 4*b), 64'hB000 + b);
    end
    for (int b = 0; b < NB; b++) peek_bank(b);
    poke(12'h410, 64'hDEAD); peek(12'h410); peek(12'h3FF); peek(12'h000);
    peek(12'h40F); peek(12'h103);

    cur_req = "R8";
    poke(12'h400, 64'h1234); peek(12'h400);
    poke(12'h400, 64'h0);    peek(12'h400);
    poke(12'h400, ONES);     peek(12'h400);
    poke(12'h101, 64'h5);    peek(12'h101);
    poke(12'h100, 64'h0);    peek(12'h100);
    poke(12'h102, 64'h3C);   peek(12'h102);
    poke(12'h102, 64'h0);
    for (int b = 0; b < NB; b++) for (int f = 1; f < 4; f++)
      poke(12'(12'h400 + 4*b + f), 64'h0);

    cur_req = "R3";
    inj(8'd4, V|U|1, 64'h1, 64'h77, 64'h88);   peek_bank(3);
    inj(8'd200, V|1, 64'h1, 64'h77, 64'h88);   peek(12'h401);
    inj(8'd0, U|1, 64'h1, 64'h77, 64'h88);     peek_bank(0); peek(12'h102);

    cur_req = "R4";
    poke(12'h101, 64'h0);
    inj(8'd1, V|U|2, 64'h1, 64'h11, 64'h22);   peek_bank(1); peek(12'h102);
    poke(12'h101, ONES);
    poke(12'h404, 64'h0);
    inj(8'd1, V|U|3, 64'h1, 64'h11, 64'h22);   peek_bank(1);
    poke(12'h404, ONES);

    cur_req = "R6";
    inj(8'd1, V|U|4, 64'h1, 64'h100, 64'h200); peek_bank(1); peek(12'h102);
    inj(8'd1, V|U|5, 64'h0, 64'h101, 64'h201);
    inj(8'd2, V|U|6, 64'h0, 64'h102, 64'h202);
    peek_bank(1); peek_bank(2); peek(12'h102);

    cur_req = "R5";
    os_mce_en = 0;
    inj(8'd3, V|U|7, 64'h1, 64'h300, 64'h400); peek_bank(3); peek(12'h102);
    os_mce_en = 1;
    poke(12'h102, 64'h4);
    inj(8'd3, V|U|8, 64'h0, 64'h300, 64'h400); peek_bank(3); peek(12'h102);
    inj(8'd3, V|9, 64'h0, 64'h310, 64'h410);   peek_bank(3);
    poke(12'h102, 64'h0);

    cur_req = "R7";
    inj(8'd3, V|10, 64'h0, 64'h320, 64'h420);  peek_bank(3);
    poke(12'h40D, 64'h0);
    inj(8'd3, V|11, 64'h0, 64'h330, 64'h430);  peek_bank(3);
    inj(8'd1, V|12, 64'h0, 64'h340, 64'h440);  peek_bank(1);
    inj(8'd0, V|13, 64'h0, 64'h350, 64'h450);  peek_bank(0);

    cur_req = "R10";
    reg_valid = 1; reg_write = 1; reg_index = 12'h402; reg_wdata = 64'hFACE;
    inj(8'd0, V|14, 64'h0, 64'h360, 64'h460); idle_in(); peek_bank(0);
    reg_valid = 1; reg_write = 1; reg_index = 12'h40F; reg_wdata = 64'hBEEF;
    inj(8'd2, V|O|15, 64'h0, 64'h370, 64'h470); idle_in(); peek_bank(3);
    peek_bank(2);
    inj(8'd0, V|U|16, 64'h0, 64'h380, 64'h480);
    peek(12'h401);

    // second instance: no global control register
    n_index = 12'h101; #1;
    chk("R9", "gctl read", n_rdata, 64'h0);
    @(negedge clk);
    n_valid = 1; n_write = 1; n_index = 12'h101; n_wdata = ONES;
    @(negedge clk);
    n_valid = 0; n_write = 0; #1;
    chk("R9", "gctl after write", n_rdata, 64'h0);
    n_index = 12'h100; #1;
    chk("R9", "cap without bit 8", n_rdata, 64'h2);
    @(negedge clk);
    n_inj = 1; n_status = V|U|1;
    @(negedge clk);
    n_inj = 0;
    chk("R9", "irq", {63'd0, n_irq}, 64'd1);
    n_index = 12'h401; #1;
    chk("R9", "status recorded", n_rdata, V|U|1);
    @(negedge clk);
    chk("R10", "irq single cycle", {63'd0, n_irq}, 64'd0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule